// File: doc/BRIEF.md
# Two-Level IO Address Table Walker

This block turns a 32-bit IO virtual address into a physical address by reading a two-level translation table held in memory. A requester hands over an address and the number of the bus master that issued it. The walker reads one root-directory word and then, if that word is valid, one second-level word, over a plain word-read port toward memory. It answers with the physical address and the 4-bit access-control index taken from the page entry. Nothing is cached, and a fresh walk is made for every request.

A directory entry or a page entry may be invalid. In that case the walker ends the walk with a failed response. It also records the fault in a per-level set of registers: a status bit, the faulting virtual address and a one-hot blame vector naming the master. Software clears status bits by pulsing ones on a clear input. The interrupt line is high while any status bit is set and enabled.

The controller is one state machine with six states. IDLE accepts a request. DIR_REQ issues the directory read and DIR_WAIT takes its reply. PTE_REQ issues the page-entry read and PTE_WAIT takes its reply. DONE presents the response for one cycle. The transitions are as follows:
- IDLE goes to DIR_REQ on a request.
- DIR_REQ goes to DIR_WAIT, and PTE_REQ goes to PTE_WAIT, when memory takes the read.
- DIR_WAIT goes to PTE_REQ on a valid directory entry, or to DONE on an invalid one (level-1 fault).
- PTE_WAIT goes to DONE on any reply, with a level-2 fault if the entry is invalid.
- DONE always returns to IDLE.

Top module: `iova_table_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_req_valid are 0, fault_status is 0 and irq is 0.
- R2: The first read of a walk is at address {tbl_base[31:2],2'b00} + 4*iova[31:20]. tbl_base is sampled when the request is accepted.
- R3: A directory word is valid only when its bits 1:0 equal 2'b01, and its bits 9:2 are ignored. On a valid word, the second read is at {dte[31:10],10'b0} + 4*iova[19:12].
- R4: A page word is valid when its bit 1 is set. Its bits 11:8, 3:2 and 0 are ignored. A valid page word gives rsp_ok=1, rsp_pa={pte[31:12], iova[11:0]} and rsp_aci=pte[7:4].
- R5: An invalid directory word ends the walk with rsp_ok=0, rsp_pa=0 and rsp_aci=0, and no second read is made. It sets fault_status[0] (the level-1 fault), loads l1_err_addr with the iova and loads l1_blame with a one-hot vector whose bit equals the master number. The level-2 registers are left unchanged.
- R6: An invalid page word ends the walk with rsp_ok=0 and sets fault_status[1] (the level-2 fault). It loads l2_err_addr with the iova and l2_blame with the one-hot master vector. The level-1 registers are left unchanged.
- R7: A one on int_clear[k] clears fault_status[k] on the next edge. If a new fault of level k arrives in the same cycle, the set wins and the bit stays 1.
- R8: irq is 1 exactly when fault_status & int_enable is nonzero (bit 0 is level 1, bit 1 is level 2).
- R9: Only one walk is in flight at a time. req_ready is 0 from the cycle after acceptance until the response has been shown. rsp_valid lasts exactly one cycle, and req_ready is 1 in the cycle after it.
- R10: While mem_req_valid is 1 and mem_req_ready is 0, mem_req_valid and mem_req_addr hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | 32 | Root directory base address (word aligned) |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_iova | input | 32 | IO virtual address to translate |
| req_master | input | MID_W | Number of the requesting master |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_pa | output | 32 | Physical address |
| rsp_aci | output | 4 | Access-control index from the page entry |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 32 | Byte address of the word read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| int_enable | input | 2 | Interrupt enable per level |
| int_clear | input | 2 | Write-ones clear pulse per level |
| fault_status | output | 2 | Level-1 (bit 0) and level-2 (bit 1) fault flags |
| l1_err_addr | output | 32 | IOVA of the last level-1 fault |
| l2_err_addr | output | 32 | IOVA of the last level-2 fault |
| l1_blame | output | NUM_MASTERS | One-hot master of the last level-1 fault |
| l2_blame | output | NUM_MASTERS | One-hot master of the last level-2 fault |
| irq | output | 1 | Enabled fault pending |

## Verification
A status clear from software and a new fault of the same level can land on the same clock edge. The bench leaves a level-1 fault pending on purpose. It then starts a walk whose directory entry is invalid, and it raises int_clear[0] exactly in the cycle the directory reply arrives. The judgment is that fault_status[0] must still be 1 afterwards and that l1_err_addr must hold the new address. A plain clear in a quiet cycle must still drop the bit.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W      = 32;
    localparam int DIR_IDX_W = 12;
    localparam int PT_IDX_W  = 8;
    localparam int OFF_W     = 12;
    localparam int ACI_W     = 4;
    localparam int PT_ALIGN  = 10;
    localparam int NUM_LVL   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_PTE_REQ,
        ST_PTE_WAIT,
        ST_DONE
    } walk_state_t;
endpackage

// File: rtl/walk_fsm.sv
module walk_fsm
    import ptw_pkg::*;
#(
    parameter int MID_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   tbl_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_iova,
    input  logic [MID_W-1:0]  req_master,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [VA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [VA_W-1:0]   mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [VA_W-1:0]   rsp_pa,
    output logic [ACI_W-1:0]  rsp_aci,
    output logic              flt_dir,
    output logic              flt_pte,
    output logic [VA_W-1:0]   flt_iova,
    output logic [MID_W-1:0]  flt_master
);
    localparam int BASE_W = VA_W - 2;
    localparam int PT_W   = VA_W - PT_ALIGN;
    localparam int PG_W   = VA_W - OFF_W;

    walk_state_t state, nxt;

    logic [VA_W-1:0]   iova_q;
    logic [MID_W-1:0]  master_q;
    logic [BASE_W-1:0] base_q;
    logic [PT_W-1:0]   pt_q;
    logic [VA_W-1:0]   pa_q;
    logic [ACI_W-1:0]  aci_q;
    logic              ok_q;

    logic dte_ok, pte_ok;
    logic unused_rsvd;

    assign dte_ok = (mem_rsp_data[1:0] == 2'b01);
    assign pte_ok = mem_rsp_data[1];
    assign unused_rsvd = ^{mem_rsp_data[9:8], mem_rsp_data[3:2], mem_rsp_data[0], tbl_base[1:0]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (req_valid) nxt = ST_DIR_REQ;
            ST_DIR_REQ:  if (mem_req_ready) nxt = ST_DIR_WAIT;
            ST_DIR_WAIT: if (mem_rsp_valid) nxt = dte_ok ? ST_PTE_REQ : ST_DONE;
            ST_PTE_REQ:  if (mem_req_ready) nxt = ST_PTE_WAIT;
            ST_PTE_WAIT: if (mem_rsp_valid) nxt = ST_DONE;
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        rsp_valid     = 1'b0;
        mem_req_addr  = '0;
        flt_dir       = 1'b0;
        flt_pte       = 1'b0;
        unique case (state)
            ST_IDLE:     req_ready = 1'b1;
            ST_DIR_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {base_q, 2'b00}
                              + {{(VA_W-DIR_IDX_W-2){1'b0}}, iova_q[VA_W-1 -: DIR_IDX_W], 2'b00};
            end
            ST_DIR_WAIT: flt_dir = mem_rsp_valid && !dte_ok;
            ST_PTE_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {pt_q, {PT_ALIGN{1'b0}}}
                              + {{(VA_W-PT_IDX_W-2){1'b0}}, iova_q[OFF_W +: PT_IDX_W], 2'b00};
            end
            ST_PTE_WAIT: flt_pte = mem_rsp_valid && !pte_ok;
            ST_DONE:     rsp_valid = 1'b1;
            default:     ;
        endcase
    end

    // walk context and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iova_q   <= '0;
            master_q <= '0;
            base_q   <= '0;
            pt_q     <= '0;
            pa_q     <= '0;
            aci_q    <= '0;
            ok_q     <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                iova_q   <= req_iova;
                master_q <= req_master;
                base_q   <= tbl_base[VA_W-1:2];
                pa_q     <= '0;
                aci_q    <= '0;
                ok_q     <= 1'b0;
            end
            if (state == ST_DIR_WAIT && mem_rsp_valid && dte_ok)
                pt_q <= mem_rsp_data[VA_W-1:PT_ALIGN];
            if (state == ST_PTE_WAIT && mem_rsp_valid && pte_ok) begin
                ok_q  <= 1'b1;
                pa_q  <= {mem_rsp_data[VA_W-1 -: PG_W], iova_q[OFF_W-1:0]};
                aci_q <= mem_rsp_data[7:4];
            end
        end
    end

    assign rsp_ok     = ok_q;
    assign rsp_pa     = pa_q;
    assign rsp_aci    = aci_q;
    assign flt_iova   = iova_q;
    assign flt_master = master_q;

    // R9
    rsp_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);
    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && req_valid |=> !req_ready);
    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    // R5
    no_read_after_l1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_dir |=> !mem_req_valid && rsp_valid && !rsp_ok);
endmodule

// File: rtl/fault_regs.sv
module fault_regs
    import ptw_pkg::*;
#(
    parameter int NUM_MASTERS = 6,
    parameter int MID_W       = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flt_dir,
    input  logic                   flt_pte,
    input  logic [VA_W-1:0]        flt_iova,
    input  logic [MID_W-1:0]       flt_master,
    input  logic [NUM_LVL-1:0]     int_enable,
    input  logic [NUM_LVL-1:0]     int_clear,
    output logic [NUM_LVL-1:0]     fault_status,
    output logic [VA_W-1:0]        l1_err_addr,
    output logic [VA_W-1:0]        l2_err_addr,
    output logic [NUM_MASTERS-1:0] l1_blame,
    output logic [NUM_MASTERS-1:0] l2_blame,
    output logic                   irq
);
    logic [NUM_LVL-1:0]     evt;
    logic [VA_W-1:0]        err_q   [NUM_LVL];
    logic [NUM_MASTERS-1:0] blame_q [NUM_LVL];
    logic [NUM_MASTERS-1:0] blame_new;

    assign evt       = {flt_pte, flt_dir};
    assign blame_new = NUM_MASTERS'(1) << flt_master;

    for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fault_status[lv] <= 1'b0;
                err_q[lv]        <= '0;
                blame_q[lv]      <= '0;
            end else if (evt[lv]) begin
                fault_status[lv] <= 1'b1;
                err_q[lv]        <= flt_iova;
                blame_q[lv]      <= blame_new;
            end else if (int_clear[lv]) begin
                fault_status[lv] <= 1'b0;
            end
        end
    end

    assign l1_err_addr = err_q[0];
    assign l2_err_addr = err_q[1];
    assign l1_blame    = blame_q[0];
    assign l2_blame    = blame_q[1];
    assign irq         = |(fault_status & int_enable);

    // R5
    l1_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_dir |=> fault_status[0] && l1_err_addr == $past(flt_iova));
    // R6
    l2_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_pte |=> fault_status[1] && l2_err_addr == $past(flt_iova));
    // R7
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_clear[0] && !flt_dir |=> !fault_status[0]);
    // R5
    blame_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(l1_blame) && $onehot0(l2_blame));
endmodule

// File: rtl/iova_table_walker.sv
module iova_table_walker
    import ptw_pkg::*;
#(
    parameter int NUM_MASTERS = 6,
    parameter int MID_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [31:0]            tbl_base,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [31:0]            req_iova,
    input  logic [MID_W-1:0]       req_master,
    output logic                   rsp_valid,
    output logic                   rsp_ok,
    output logic [31:0]            rsp_pa,
    output logic [3:0]             rsp_aci,
    output logic                   mem_req_valid,
    input  logic                   mem_req_ready,
    output logic [31:0]            mem_req_addr,
    input  logic                   mem_rsp_valid,
    input  logic [31:0]            mem_rsp_data,
    input  logic [1:0]             int_enable,
    input  logic [1:0]             int_clear,
    output logic [1:0]             fault_status,
    output logic [31:0]            l1_err_addr,
    output logic [31:0]            l2_err_addr,
    output logic [NUM_MASTERS-1:0] l1_blame,
    output logic [NUM_MASTERS-1:0] l2_blame,
    output logic                   irq
);
    logic             flt_dir, flt_pte;
    logic [31:0]      flt_iova;
    logic [MID_W-1:0] flt_master;

    walk_fsm #(.MID_W(MID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_iova(req_iova), .req_master(req_master),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_pa(rsp_pa), .rsp_aci(rsp_aci),
        .flt_dir(flt_dir), .flt_pte(flt_pte),
        .flt_iova(flt_iova), .flt_master(flt_master)
    );

    fault_regs #(.NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)) u_faults (
        .clk(clk), .rst_n(rst_n),
        .flt_dir(flt_dir), .flt_pte(flt_pte),
        .flt_iova(flt_iova), .flt_master(flt_master),
        .int_enable(int_enable), .int_clear(int_clear),
        .fault_status(fault_status),
        .l1_err_addr(l1_err_addr), .l2_err_addr(l2_err_addr),
        .l1_blame(l1_blame), .l2_blame(l2_blame),
        .irq(irq)
    );
endmodule

// File: tb/iova_table_walker_test.sv
`timescale 1ns/1ps
module iova_table_walker_test;
    localparam int NM = 6;
    localparam int MW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] tbl_base = 32'h0010_0000;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [31:0] req_iova = '0;
    logic [MW-1:0] req_master = '0;
    logic rsp_valid, rsp_ok;
    logic [31:0] rsp_pa;
    logic [3:0] rsp_aci;
    logic mem_req_valid;
    logic mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [1:0] int_enable = 2'b00;
    logic [1:0] int_clear = 2'b00;
    logic [1:0] fault_status;
    logic [31:0] l1_err_addr, l2_err_addr;
    logic [NM-1:0] l1_blame, l2_blame;
    logic irq;

    int checks = 0;
    int fails = 0;
    bit stall_en = 1'b0;
    int n_reads = 0;
    logic [31:0] rd_addr [2];

    always #4 clk = ~clk;

    iova_table_walker #(.NUM_MASTERS(NM)) uut (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_iova(req_iova), .req_master(req_master),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_pa(rsp_pa), .rsp_aci(rsp_aci),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .int_enable(int_enable), .int_clear(int_clear),
        .fault_status(fault_status),
        .l1_err_addr(l1_err_addr), .l2_err_addr(l2_err_addr),
        .l1_blame(l1_blame), .l2_blame(l2_blame), .irq(irq)
    );

    // table contents, derived from addresses
    function automatic logic [31:0] pt_addr(input int unsigned d);
        return 32'h8000_0000 + (d << 10);
    endfunction
    function automatic bit dir_valid(input int unsigned d);
        return (d % 6) >= 2;
    endfunction
    function automatic logic [31:0] dir_word(input int unsigned d);
        logic [31:0] p;
        p = pt_addr(d);
        if (d % 6 == 0) return 32'h0;
        if (d % 6 == 1) return {p[31:10], 8'hA5, 2'b11};
        return {p[31:10], 8'h5A, 2'b01};
    endfunction
    function automatic bit pte_valid(input int unsigned d, input int unsigned j);
        return ((d + j) % 7) != 0;
    endfunction
    function automatic logic [19:0] page_of(input int unsigned d, input int unsigned j);
        logic [31:0] h;
        h = ((d * 256 + j) * 32'h9E37) ^ 32'h13579;
        return h[19:0];
    endfunction
    function automatic logic [3:0] aci_of(input int unsigned d, input int unsigned j);
        return 4'((d ^ j) & 15);
    endfunction
    function automatic logic [31:0] pte_word(input int unsigned d, input int unsigned j);
        if (!pte_valid(d, j)) return {20'hABCDE, 4'hF, 4'h3, 2'b11, 1'b0, 1'b1};
        return {page_of(d, j), 4'hF, aci_of(d, j), 2'b11, 1'b1, 1'b1};
    endfunction
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] off;
        if (a >= 32'h8000_0000) begin
            off = a - 32'h8000_0000;
            return pte_word(int'(off >> 10), int'((off >> 2) & 255));
        end
        off = a - {tbl_base[31:2], 2'b00};
        return dir_word(int'(off >> 2));
    endfunction

    // memory model: one-cycle response
    always @(posedge clk) begin
        mem_rsp_valid <= mem_req_valid && mem_req_ready;
        mem_rsp_data  <= mem_word(mem_req_addr);
        if (mem_req_valid && mem_req_ready) begin
            if (n_reads < 2) rd_addr[n_reads] <= mem_req_addr;
            n_reads <= n_reads + 1;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            mem_req_ready = stall_en ? 1'($urandom % 2) : 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one walk; clr_on_rsp pulses int_clear in the cycle a memory reply arrives
    task automatic walk(input logic [31:0] va, input int unsigned m, input logic [1:0] clr_on_rsp);
        int unsigned d, j;
        logic [1:0] st_before;
        logic [31:0] l1a_before, l2a_before;
        logic [NM-1:0] bl;
        int wait_n;
        d = va[31:20];
        j = va[19:12];
        bl = NM'(1) << m;
        @(negedge clk);
        st_before = fault_status;
        l1a_before = l1_err_addr;
        l2a_before = l2_err_addr;
        n_reads = 0;
        req_iova = va;
        req_master = MW'(m);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R9 busy after accept", 32'(req_ready), 32'h0);
        wait_n = 0;
        while (!rsp_valid && wait_n < 100) begin
            int_clear = mem_rsp_valid ? clr_on_rsp : 2'b00;
            @(negedge clk);
            wait_n++;
        end
        int_clear = 2'b00;
        chk(rsp_valid, "R9 response arrives", 32'(rsp_valid), 32'h1);
        chk(rd_addr[0] == {tbl_base[31:2], 2'b00} + (d << 2), "R2 directory address",
            rd_addr[0], {tbl_base[31:2], 2'b00} + (d << 2));
        if (!dir_valid(d)) begin
            chk(!rsp_ok && rsp_pa == 0 && rsp_aci == 0, "R5 failed rsp", {rsp_ok, 27'h0, rsp_aci}, 32'h0);
            chk(n_reads == 1, "R5 single read", 32'(n_reads), 32'h1);
            chk(fault_status[0] && l1_err_addr == va, "R5 l1 addr", l1_err_addr, va);
            chk(l1_blame == bl, "R5 l1 blame", 32'(l1_blame), 32'(bl));
            chk(fault_status[1] == st_before[1] && l2_err_addr == l2a_before, "R5 l2 untouched",
                l2_err_addr, l2a_before);
        end else begin
            chk(n_reads == 2 && rd_addr[1] == pt_addr(d) + (j << 2), "R3 table address",
                rd_addr[1], pt_addr(d) + (j << 2));
            if (pte_valid(d, j)) begin
                chk(rsp_ok && rsp_pa == {page_of(d, j), va[11:0]}, "R4 physical address",
                    rsp_pa, {page_of(d, j), va[11:0]});
                chk(rsp_aci == aci_of(d, j), "R4 aci", 32'(rsp_aci), 32'(aci_of(d, j)));
                chk(fault_status == st_before, "R4 no new fault", 32'(fault_status), 32'(st_before));
            end else begin
                chk(!rsp_ok, "R6 failed rsp", 32'(rsp_ok), 32'h0);
                chk(fault_status[1] && l2_err_addr == va, "R6 l2 addr", l2_err_addr, va);
                chk(l2_blame == bl, "R6 l2 blame", 32'(l2_blame), 32'(bl));
                chk(fault_status[0] == st_before[0] && l1_err_addr == l1a_before, "R6 l1 untouched",
                    l1_err_addr, l1a_before);
            end
        end
        chk(irq == |(fault_status & int_enable), "R8 irq", 32'(irq), 32'(|(fault_status & int_enable)));
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R9 one-cycle rsp", {30'h0, rsp_valid, req_ready}, 32'h1);
    endtask

    task automatic clear_all();
        @(negedge clk);
        int_clear = 2'b11;
        @(negedge clk);
        int_clear = 2'b00;
        chk(fault_status == 2'b00, "R7 clear", 32'(fault_status), 32'h0);
    endtask

    function automatic logic [31:0] mk_va(input int unsigned d, input int unsigned j, input int unsigned o);
        return {12'(d), 8'(j), 12'(o)};
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1
        chk(req_ready && !rsp_valid && !mem_req_valid && fault_status == 0 && !irq, "R1 reset state",
            {27'h0, req_ready, rsp_valid, mem_req_valid, fault_status}, 32'h10);
        rst_n = 1'b1;
        // directed corners: R3 reserved bits ignored, offset max, top directory index
        walk(mk_va(2, 1, 12'hFFF), 0, 2'b00);
        walk(mk_va(4095, 255, 12'h123), 5, 2'b00);
        // R5 invalid 00 and 11 encodings
        int_enable = 2'b10;
        walk(mk_va(6, 3, 0), 3, 2'b00);
        chk(!irq, "R8 masked level", 32'(irq), 32'h0);
        int_enable = 2'b01;
        @(negedge clk);
        chk(irq, "R8 enabled level", 32'(irq), 32'h1);
        walk(mk_va(7, 3, 4), 2, 2'b00);
        // R7 set wins over clear in the same cycle
        walk(mk_va(12, 9, 8), 4, 2'b01);
        chk(fault_status[0] && l1_err_addr == mk_va(12, 9, 8), "R7 set wins",
            l1_err_addr, mk_va(12, 9, 8));
        clear_all();
        // R6 invalid page: d=2,j=5 -> 7
        int_enable = 2'b11;
        walk(mk_va(2, 5, 16), 1, 2'b00);
        clear_all();
        chk(!irq, "R8 irq drops", 32'(irq), 32'h0);
        // R10 random stalls plus random walks
        stall_en = 1'b1;
        for (int i = 0; i < 60; i++) begin
            walk($urandom, $urandom % NM, 2'b00);
            if (i % 10 == 9) clear_all();
        end
        // R2 base change between walks
        tbl_base = 32'h0004_0004;
        walk(mk_va(3, 4, 5), 1, 2'b00);
        walk(mk_va(9, 0, 5), 2, 2'b00);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule